// File: doc/BRIEF.md
# Platform-Level Interrupt Router

This block collects interrupt requests from up to 63 sources and delivers them to a small set of processor contexts, two by default. Every source owns a priority and a gateway that turns a level-high or rising-edge request into a pending bit. Every context owns a vector of per-source enable bits, a priority threshold and one claim/complete register. A context's interrupt line rises when some source is pending, enabled for that context and of priority strictly above that context's threshold.

Software reaches all state through a word-addressed register bus with separate read and write strobes. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. Reading a context's claim/complete word returns the winning source ID and takes that source out of the pending set. Writing the same ID back completes the source and lets its gateway forward the next request. Word addresses are given below; the byte offset of a word is four times its word address.

Word map (word addresses): source priority at word s (1..N); pending array at 0x400+w; gateway trigger-mode array at 0x600+w (bit set means rising-edge); enables of context c at 0x800 + 0x20·c + w; threshold of context c at 0x80000 + 0x400·c; claim/complete of context c at 0x80000 + 0x400·c + 1. In every bit array, source s sits in word w = s/32 at bit s%32.

Top module: `irq_router`

## Requirements
- R1: Source ID 0 is reserved: the priority word at address 0 reads 0 and ignores writes, and bit 0 of word 0 of the pending, trigger-mode and enable arrays always reads 0.
- R2: A source with priority 0 is never delivered or claimed, though its pending bit still sets and reads back as 1.
- R3: A source is eligible for a context only when its priority is strictly greater than that context's threshold; with 3-bit priorities a threshold of 7 blocks every source.
- R4: Only sources that are pending and enabled for a context can be claimed by it; a source that no context enables still becomes pending.
- R5: A read of a context's claim/complete word returns the ID of the winning eligible source and clears its pending bit; with no eligible source it returns 0.
- R6: Among eligible sources the highest priority wins, and equal priorities go to the lower ID.
- R7: Each context's interrupt line is registered: it is 1 one cycle after that context has an eligible source and 0 one cycle after it has none.
- R8: A write of source ID s to a context's claim/complete word completes s only if s is enabled for that context at the time of the write; otherwise it has no effect.
- R9: In level mode, once a source is claimed its gateway sets no new pending bit until it is completed; a completion with the request still high sets the pending bit again.
- R10: In rising-edge mode a request pends on a 0-to-1 transition only; a steady high does not re-trigger, and exactly one edge arriving between claim and completion becomes a new pending request after completion.
- R11: After reset all priorities, thresholds, enables, trigger modes and pending bits are 0 and every context interrupt line is low.
- R12: Source s appears in array word s/32 at bit s%32, including source 63 in word 1 bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Source requests; bit k carries source k+1 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 20 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ctx_irq | output | NUM_CTX | Interrupt line per context |

## Verification
The assertions assume that the read and write strobes are never raised in the same cycle, so at most one claim and at most one completion reach the gateways per cycle. They also rely on source requests changing only between clock edges. The directed bench drives every bus operation and request change on the falling edge, issues one bus operation at a time, and resets before each scenario so every gateway starts idle.

// File: rtl/irqr_pkg.sv
`timescale 1ns/1ps
package irqr_pkg;

    localparam int ADDR_W     = 20;
    localparam int PEND_BASE  = 'h400;
    localparam int TRIG_BASE  = 'h600;
    localparam int EN_BASE    = 'h800;
    localparam int EN_STRIDE  = 'h20;
    localparam int CTX_BASE   = 'h80000;
    localparam int CTX_STRIDE = 'h400;
    localparam int THR_OFS    = 0;
    localparam int CLAIM_OFS  = 1;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PRIO,
        REG_PEND,
        REG_TRIG,
        REG_EN,
        REG_THR,
        REG_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [15:0] index;
        logic [7:0]  ctx;
    } reg_sel_t;

    typedef struct packed {
        logic pend;
        logic busy;
        logic held;
        logic prev;
    } gw_state_t;

    function automatic int word_count(int nsrc);
        return (nsrc + 32) / 32;
    endfunction

    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int nsrc, int nctx);
        reg_sel_t r;
        int ai;
        int nw;
        ai = int'(a);
        nw = word_count(nsrc);
        r.kind  = REG_NONE;
        r.index = '0;
        r.ctx   = '0;
        if (ai >= 1 && ai <= nsrc) begin
            r.kind  = REG_PRIO;
            r.index = 16'(ai);
        end else if (ai >= PEND_BASE && ai < PEND_BASE + nw) begin
            r.kind  = REG_PEND;
            r.index = 16'(ai - PEND_BASE);
        end else if (ai >= TRIG_BASE && ai < TRIG_BASE + nw) begin
            r.kind  = REG_TRIG;
            r.index = 16'(ai - TRIG_BASE);
        end
        for (int c = 0; c < nctx; c++) begin
            if (ai >= EN_BASE + c * EN_STRIDE && ai < EN_BASE + c * EN_STRIDE + nw) begin
                r.kind  = REG_EN;
                r.index = 16'(ai - EN_BASE - c * EN_STRIDE);
                r.ctx   = 8'(c);
            end
            if (ai == CTX_BASE + c * CTX_STRIDE + THR_OFS) begin
                r.kind = REG_THR;
                r.ctx  = 8'(c);
            end
            if (ai == CTX_BASE + c * CTX_STRIDE + CLAIM_OFS) begin
                r.kind = REG_CLAIM;
                r.ctx  = 8'(c);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqr_gateway.sv
`timescale 1ns/1ps
module irqr_gateway
    import irqr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o
);

    gw_state_t st_q;
    gw_state_t st_d;
    logic      rise;
    logic      new_req;

    always_comb begin
        rise    = req_i & ~st_q.prev;
        new_req = edge_mode_i ? rise : req_i;
        st_d      = st_q;
        st_d.prev = req_i;
        if (claim_i) begin
            st_d.pend = 1'b0;
            st_d.busy = 1'b1;
            st_d.held = edge_mode_i && rise;
        end else if (complete_i && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.held = 1'b0;
            if (edge_mode_i ? (st_q.held || rise) : req_i) begin
                st_d.pend = 1'b1;
            end
        end else if (new_req) begin
            if (!st_q.pend && !st_q.busy) begin
                st_d.pend = 1'b1;
            end else if (st_q.busy && edge_mode_i) begin
                st_d.held = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R9
    pend_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(st_q.pend && st_q.busy));

    // R5
    claim_takes_chk: assert property (@(posedge clk) disable iff (rst)
        claim_i |=> (st_q.busy && !pend_o));

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !complete_i) |=> !pend_o);

    // R10
    edge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && st_q.busy && st_q.held && complete_i && !claim_i) |=> pend_o);

endmodule

// File: rtl/irqr_arbiter.sv
`timescale 1ns/1ps
module irqr_arbiter #(
    parameter int NUM_SRC = 63,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC:1]               pend_i,
    input  logic [NUM_SRC:1]               en_i,
    input  logic [NUM_SRC:1][PRIO_W-1:0]   prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                best_id_o,
    output logic                           irq_o
);

    logic [PRIO_W-1:0] best_prio;

    // Linear scan: strict greater-than keeps the lower ID on a tie.
    always_comb begin
        best_prio = '0;
        best_id_o = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (pend_i[s] && en_i[s] && (prio_i[s] > thr_i) && (prio_i[s] > best_prio)) begin
                best_prio = prio_i[s];
                best_id_o = ID_W'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= (best_id_o != '0);
        end
    end

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_chk
        // R4
        elig_seen_chk: assert property (@(posedge clk) disable iff (rst)
            (pend_i[s] && en_i[s] && (prio_i[s] > thr_i)) |-> (best_id_o != '0));
        // R3
        winner_valid_chk: assert property (@(posedge clk) disable iff (rst)
            (best_id_o == ID_W'(s)) |-> (pend_i[s] && en_i[s] && (prio_i[s] > thr_i)));
    end

endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
    import irqr_pkg::*;
#(
    parameter int NUM_SRC = 63,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CTX-1:0]  ctx_irq
);

    localparam int NUM_WORDS = word_count(NUM_SRC);
    localparam int FLAT_W    = NUM_WORDS * 32;
    localparam int ID_W      = $clog2(NUM_SRC + 1);
    localparam logic [FLAT_W-1:0] VALID_MASK =
        ((FLAT_W'(1) << (NUM_SRC + 1)) - FLAT_W'(1)) & ~FLAT_W'(1);

    reg_sel_t                       dec;
    logic [NUM_SRC:1][PRIO_W-1:0]   prio_q;
    logic [FLAT_W-1:0]              trig_q;
    logic [FLAT_W-1:0]              en_q  [NUM_CTX];
    logic [PRIO_W-1:0]              thr_q [NUM_CTX];
    logic [ID_W-1:0]                best_id [NUM_CTX];
    logic [NUM_SRC:1]               pend_vec;
    logic [FLAT_W-1:0]              pend_flat;
    logic [NUM_SRC:1]               claim_vec;
    logic [NUM_SRC:1]               complete_vec;
    logic [31:0]                    rd_word;

    assign dec = decode_addr(bus_addr, NUM_SRC, NUM_CTX);

    always_comb begin
        pend_flat            = '0;
        pend_flat[NUM_SRC:1] = pend_vec;
    end

    // Claim and completion pulses toward the gateways.
    always_comb begin
        claim_vec    = '0;
        complete_vec = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (dec.kind == REG_CLAIM && dec.ctx == 8'(c)) begin
                for (int s = 1; s <= NUM_SRC; s++) begin
                    if (bus_rd && best_id[c] == ID_W'(s)) begin
                        claim_vec[s] = 1'b1;
                    end
                    if (bus_wr && bus_wdata == 32'(s) && en_q[c][s]) begin
                        complete_vec[s] = 1'b1;
                    end
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_word = '0;
        case (dec.kind)
            REG_PRIO: begin
                for (int s = 1; s <= NUM_SRC; s++) begin
                    if (dec.index == 16'(s)) rd_word = 32'(prio_q[s]);
                end
            end
            REG_PEND: begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (dec.index == 16'(w)) rd_word = pend_flat[32*w +: 32];
                end
            end
            REG_TRIG: begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (dec.index == 16'(w)) rd_word = trig_q[32*w +: 32];
                end
            end
            REG_EN: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    for (int w = 0; w < NUM_WORDS; w++) begin
                        if (dec.ctx == 8'(c) && dec.index == 16'(w)) rd_word = en_q[c][32*w +: 32];
                    end
                end
            end
            REG_THR: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (dec.ctx == 8'(c)) rd_word = 32'(thr_q[c]);
                end
            end
            REG_CLAIM: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (dec.ctx == 8'(c)) rd_word = 32'(best_id[c]);
                end
            end
            default: rd_word = '0;
        endcase
    end

    // Configuration registers and registered read data.
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q    <= '0;
            trig_q    <= '0;
            bus_rdata <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else begin
            if (bus_rd) begin
                bus_rdata <= rd_word;
            end
            if (bus_wr) begin
                case (dec.kind)
                    REG_PRIO: begin
                        for (int s = 1; s <= NUM_SRC; s++) begin
                            if (dec.index == 16'(s)) prio_q[s] <= bus_wdata[PRIO_W-1:0];
                        end
                    end
                    REG_TRIG: begin
                        for (int w = 0; w < NUM_WORDS; w++) begin
                            if (dec.index == 16'(w))
                                trig_q[32*w +: 32] <= bus_wdata & VALID_MASK[32*w +: 32];
                        end
                    end
                    REG_EN: begin
                        for (int c = 0; c < NUM_CTX; c++) begin
                            for (int w = 0; w < NUM_WORDS; w++) begin
                                if (dec.ctx == 8'(c) && dec.index == 16'(w))
                                    en_q[c][32*w +: 32] <= bus_wdata & VALID_MASK[32*w +: 32];
                            end
                        end
                    end
                    REG_THR: begin
                        for (int c = 0; c < NUM_CTX; c++) begin
                            if (dec.ctx == 8'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gw
        irqr_gateway u_gw (
            .clk         (clk),
            .rst         (rst),
            .req_i       (src_req[s-1]),
            .edge_mode_i (trig_q[s]),
            .claim_i     (claim_vec[s]),
            .complete_i  (complete_vec[s]),
            .pend_o      (pend_vec[s])
        );
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irqr_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_arb (
            .clk       (clk),
            .rst       (rst),
            .pend_i    (pend_vec),
            .en_i      (en_q[c][NUM_SRC:1]),
            .prio_i    (prio_q),
            .thr_i     (thr_q[c]),
            .best_id_o (best_id[c]),
            .irq_o     (ctx_irq[c])
        );
    end

    // R5 (input assumption: one bus operation per cycle)
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R5
    claim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_vec));

    // R8
    complete_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(complete_vec));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctx_irq == '0));

endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

    localparam int NSRC = 63;
    localparam int NCTX = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_req = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [19:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCTX-1:0]   ctx_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_router #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(3)) i_irq_router (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctx_irq   (ctx_irq)
    );

    function automatic int a_prio(int s);       return s; endfunction
    function automatic int a_pend(int w);       return 'h400 + w; endfunction
    function automatic int a_trig(int w);       return 'h600 + w; endfunction
    function automatic int a_en(int c, int w);  return 'h800 + c * 'h20 + w; endfunction
    function automatic int a_thr(int c);        return 'h80000 + c * 'h400; endfunction
    function automatic int a_clm(int c);        return 'h80000 + c * 'h400 + 1; endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 20'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 20'(a);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        src_req = '0;
        bus_rd  = 1'b0;
        bus_wr  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R11 irq after reset", 32'(ctx_irq), 32'h0);
        rd(a_pend(0), d);  chk("R11 pending after reset", d, 32'h0);
        rd(a_prio(5), d);  chk("R11 priority after reset", d, 32'h0);
        rd(a_thr(1), d);   chk("R11 threshold after reset", d, 32'h0);
        rd(a_en(0, 1), d); chk("R11 enable after reset", d, 32'h0);
        rd(a_clm(0), d);   chk("R11 claim after reset", d, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        do_reset();
        wr(a_prio(5), 3);
        wr(a_en(0, 0), 32'h20);
        @(negedge clk); src_req[4] = 1'b1;
        settle();
        chk("R7 irq raised on context 0 only", 32'(ctx_irq), 32'h1);
        rd(a_pend(0), d);  chk("R12 source 5 in word 0 bit 5", d, 32'h20);
        rd(a_clm(0), d);   chk("R5 claim returns 5", d, 32'd5);
        repeat (2) @(negedge clk);
        chk("R7 irq drops after claim", 32'(ctx_irq), 32'h0);
        rd(a_pend(0), d);  chk("R9 no re-pend before completion", d, 32'h0);
        wr(a_clm(0), 5);
        settle();
        rd(a_pend(0), d);  chk("R9 re-pend after completion with level high", d, 32'h20);
        rd(a_clm(0), d);   chk("R5 second claim returns 5", d, 32'd5);
        @(negedge clk); src_req[4] = 1'b0;
        wr(a_clm(0), 5);
        settle();
        rd(a_pend(0), d);  chk("R9 no pend after completion with level low", d, 32'h0);
        rd(a_clm(0), d);   chk("R5 claim with nothing eligible returns 0", d, 32'h0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        do_reset();
        wr(a_prio(3), 2);
        wr(a_prio(10), 5);
        wr(a_prio(40), 5);
        wr(a_prio(63), 5);
        wr(a_en(1, 0), (32'h1 << 3) | (32'h1 << 10));
        wr(a_en(1, 1), (32'h1 << 8) | (32'h1 << 31));
        @(negedge clk);
        src_req[2] = 1'b1; src_req[9] = 1'b1; src_req[39] = 1'b1; src_req[62] = 1'b1;
        settle();
        chk("R7 irq on context 1 only", 32'(ctx_irq), 32'h2);
        rd(a_pend(1), d);  chk("R12 sources 40 and 63 in word 1", d, 32'h8000_0100);
        rd(a_clm(1), d);   chk("R6 first winner is 10", d, 32'd10);
        rd(a_clm(1), d);   chk("R6 tie goes to 40", d, 32'd40);
        rd(a_clm(1), d);   chk("R6 then 63", d, 32'd63);
        rd(a_clm(1), d);   chk("R6 lowest priority 3 last", d, 32'd3);
        rd(a_clm(1), d);   chk("R5 none left", d, 32'd0);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        do_reset();
        wr(a_prio(7), 4);
        wr(a_en(0, 0), 32'h80);
        wr(a_thr(0), 4);
        @(negedge clk); src_req[6] = 1'b1;
        settle();
        chk("R3 priority equal to threshold gives no irq", 32'(ctx_irq), 32'h0);
        rd(a_clm(0), d);   chk("R3 claim at equal threshold returns 0", d, 32'h0);
        rd(a_pend(0), d);  chk("R3 source still pending", d, 32'h80);
        wr(a_thr(0), 3);
        settle();
        chk("R3 priority above threshold raises irq", 32'(ctx_irq), 32'h1);
        wr(a_prio(7), 7);
        wr(a_thr(0), 7);
        settle();
        chk("R3 threshold 7 blocks", 32'(ctx_irq), 32'h0);
        rd(a_clm(0), d);   chk("R3 claim under threshold 7 returns 0", d, 32'h0);
    endtask

    task automatic t_prio0();
        logic [31:0] d;
        do_reset();
        wr(a_en(0, 0), 32'h1000);
        @(negedge clk); src_req[11] = 1'b1;
        settle();
        chk("R2 priority 0 gives no irq", 32'(ctx_irq), 32'h0);
        rd(a_pend(0), d);  chk("R2 priority 0 source pends", d, 32'h1000);
        rd(a_clm(0), d);   chk("R2 priority 0 never claimed", d, 32'h0);
        wr(a_prio(12), 1);
        settle();
        rd(a_clm(0), d);   chk("R2 claimable once priority set", d, 32'd12);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        do_reset();
        wr(a_prio(20), 3);
        wr(a_en(1, 0), 32'h0010_0000);
        @(negedge clk); src_req[19] = 1'b1;
        settle();
        chk("R4 only the enabled context interrupts", 32'(ctx_irq), 32'h2);
        rd(a_clm(0), d);   chk("R4 disabled context claims nothing", d, 32'h0);
        rd(a_pend(0), d);  chk("R4 pending bit set", d, 32'h0010_0000);
        rd(a_clm(1), d);   chk("R4 enabled context claims 20", d, 32'd20);
        do_reset();
        wr(a_prio(21), 3);
        @(negedge clk); src_req[20] = 1'b1;
        settle();
        rd(a_pend(0), d);  chk("R4 source enabled nowhere still pends", d, 32'h0020_0000);
    endtask

    task automatic t_complete_ignored();
        logic [31:0] d;
        do_reset();
        wr(a_prio(6), 2);
        wr(a_en(0, 0), 32'h40);
        @(negedge clk); src_req[5] = 1'b1;
        settle();
        rd(a_clm(0), d);   chk("R8 claim returns 6", d, 32'd6);
        wr(a_en(0, 0), 32'h0);
        wr(a_clm(0), 6);
        settle();
        rd(a_pend(0), d);  chk("R8 completion while disabled ignored", d, 32'h0);
        wr(a_en(0, 0), 32'h40);
        settle();
        rd(a_pend(0), d);  chk("R8 still held after re-enable", d, 32'h0);
        wr(a_clm(1), 6);
        settle();
        rd(a_pend(0), d);  chk("R8 completion from non-enabled context ignored", d, 32'h0);
        wr(a_clm(0), 6);
        settle();
        rd(a_pend(0), d);  chk("R8 completion while enabled accepted", d, 32'h40);
    endtask

    task automatic pulse(input int bitpos);
        @(negedge clk); src_req[bitpos] = 1'b1;
        @(negedge clk); src_req[bitpos] = 1'b0;
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        wr(a_trig(0), 32'h200);
        wr(a_prio(9), 2);
        wr(a_en(0, 0), 32'h200);
        pulse(8);
        settle();
        rd(a_pend(0), d);  chk("R10 edge pends", d, 32'h200);
        rd(a_clm(0), d);   chk("R10 claim returns 9", d, 32'd9);
        pulse(8);
        pulse(8);
        settle();
        rd(a_pend(0), d);  chk("R10 edges held off while claimed", d, 32'h0);
        wr(a_clm(0), 9);
        settle();
        rd(a_pend(0), d);  chk("R10 one kept edge pends after completion", d, 32'h200);
        rd(a_clm(0), d);   chk("R10 claim kept edge", d, 32'd9);
        wr(a_clm(0), 9);
        settle();
        rd(a_pend(0), d);  chk("R10 only one edge kept", d, 32'h0);
        @(negedge clk); src_req[8] = 1'b1;
        settle();
        rd(a_clm(0), d);   chk("R10 steady high pends once", d, 32'd9);
        wr(a_clm(0), 9);
        settle();
        rd(a_pend(0), d);  chk("R10 steady high does not re-trigger", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        do_reset();
        wr(a_prio(0), 7);
        rd(a_prio(0), d);  chk("R1 priority word 0 reads 0", d, 32'h0);
        wr(a_en(0, 0), 32'hFFFF_FFFF);
        rd(a_en(0, 0), d); chk("R1 enable bit 0 reads 0", d, 32'hFFFF_FFFE);
        wr(a_trig(0), 32'hFFFF_FFFF);
        rd(a_trig(0), d);  chk("R1 trigger bit 0 reads 0", d, 32'hFFFF_FFFE);
        wr(a_clm(0), 0);
        rd(a_pend(0), d);  chk("R1 completion of ID 0 harmless", d, 32'h0);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_arb();
        t_thresh();
        t_prio0();
        t_disabled();
        t_complete_ignored();
        t_edge();
        t_reserved();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule